// File: doc/BRIEF.md
# Write-Transaction Command and Display-Data Sorter

This block sits behind a byte-level two-wire serial slave front end that already detects START and STOP conditions and assembles complete received bytes. For each write transaction to a segment display controller it checks the device address, decides whether the current byte is acknowledged, and sorts the rest of the bytes into command bytes and display-data bytes.

The first byte after a START has to match the fixed write address (0x7C by default). If it does not match, the transaction is dead: nothing is acknowledged and nothing is produced until the next START. After an accepted address, the next byte is always a command. The top bit of each command byte is a continuation flag. When it is 1, another command follows. When it is 0, every later byte of the transaction is display data. A new START is the only way to issue commands again. Downstream logic receives a command strobe with the 7-bit payload and a data strobe with the full byte. It does not decode the commands.

All outputs are registered. They pulse for one cycle, in the cycle after the clock edge that sampled the byte event.

Top module: `segStreamSorter`

## Requirements
- R1: After reset, and before any START has been seen, received bytes produce no acknowledge, no command strobe and no data strobe.
- R2: After a START, the first byte is acknowledged (ackOut high) only when it equals the device address 0x7C. The address byte itself never produces a command or data strobe.
- R3: If the first byte after a START does not equal 0x7C, that byte and every later byte are not acknowledged and produce no strobe, until the next START.
- R4: The byte that follows an accepted address is always a command. It raises cmdStrobe and ackOut, and cmdPayload carries the byte's bits 6..0.
- R5: A command byte whose bit 7 is 1 makes the next byte a command as well.
- R6: A command byte whose bit 7 is 0 makes every later byte of the transaction display data. Each such byte raises dataStrobe and ackOut, and dataByte equals the byte, whatever the value of its bit 7.
- R7: A byte event that arrives in the same cycle as a START or STOP event is cancelled. It produces no acknowledge and no strobe. When START and STOP coincide, START wins.
- R8: A STOP returns the block to idle. Bytes received after it are ignored until a START.
- R9: A repeated START begins address matching again from any phase, including the display-data phase.
- R10: Each output pulses in the cycle after the edge that sampled byteValid. cmdStrobe and dataStrobe are never high together, and a strobe is always accompanied by ackOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEv | input | 1 | START or repeated START detected (one-cycle pulse) |
| stopEv | input | 1 | STOP detected (one-cycle pulse) |
| byteValid | input | 1 | A complete byte has been received (one-cycle pulse) |
| byteData | input | 8 | Received byte, MSB first on the wire |
| ackOut | output | 1 | Acknowledge decision for the last byte |
| cmdStrobe | output | 1 | Command byte accepted |
| cmdPayload | output | 7 | Lower seven bits of the command byte |
| dataStrobe | output | 1 | Display-data byte accepted |
| dataByte | output | 8 | Display-data byte |

## Verification
Two functions can fall in the same cycle: a byte arriving and a START or STOP condition that cancels it. The bench provokes this by raising byteValid in the same cycle as startEv, as stopEv, and as both together, in the command phase and in the data phase. The cycle after, it expects no acknowledge and no strobe. It then sends one more byte and checks it against the phase that the winning event should have selected, so a design that let the byte through, or advanced state on it, is caught.

// File: rtl/seg_sorter_pkg.sv
package seg_sorter_pkg;

  localparam int BYTE_W = 8;
  localparam int PAY_W  = BYTE_W - 1;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_CMD    = 3'd2,
    PH_DATA   = 3'd3,
    PH_REJECT = 3'd4
  } phase_t;

  typedef struct packed {
    logic ack;
    logic cmd;
    logic data;
  } strobes_t;

endpackage

// File: rtl/seg_sorter_ctrl.sv
module seg_sorter_ctrl
  import seg_sorter_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'h7C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output strobes_t          stb
);

  phase_t phase, phaseNext;
  logic   cancelByte;
  logic   takeByte;
  logic   contFlag;

  assign cancelByte = startEv || stopEv;
  assign takeByte   = byteValid && !cancelByte;
  assign contFlag   = byteData[BYTE_W-1];

  always_comb begin
    phaseNext = phase;
    stb       = '0;
    if (startEv) begin
      phaseNext = PH_ADDR;
    end else if (stopEv) begin
      phaseNext = PH_IDLE;
    end else if (takeByte) begin
      unique case (phase)
        PH_ADDR: begin
          if (byteData == DEV_ADDR) begin
            stb.ack   = 1'b1;
            phaseNext = PH_CMD;
          end else begin
            phaseNext = PH_REJECT;
          end
        end
        PH_CMD: begin
          stb.ack   = 1'b1;
          stb.cmd   = 1'b1;
          phaseNext = contFlag ? PH_CMD : PH_DATA;
        end
        PH_DATA: begin
          stb.ack  = 1'b1;
          stb.data = 1'b1;
        end
        default: phaseNext = phase;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  AST_DATA_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA && !startEv) |=> (phase == PH_DATA || phase == PH_IDLE)); // R6

  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_REJECT && !startEv && !stopEv) |=> (phase == PH_REJECT)); // R3

  AST_START_REARM: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (phase == PH_ADDR)); // R9

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stopEv && !startEv) |=> (phase == PH_IDLE)); // R8

endmodule

// File: rtl/seg_sorter_dpath.sv
module seg_sorter_dpath
  import seg_sorter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [BYTE_W-1:0] byteData,
  output logic              ackOut,
  output logic              cmdStrobe,
  output logic [PAY_W-1:0]  cmdPayload,
  output logic              dataStrobe,
  output logic [BYTE_W-1:0] dataByte
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackOut     <= 1'b0;
      cmdStrobe  <= 1'b0;
      dataStrobe <= 1'b0;
      cmdPayload <= '0;
      dataByte   <= '0;
    end else begin
      ackOut     <= stb.ack;
      cmdStrobe  <= stb.cmd;
      dataStrobe <= stb.data;
      if (stb.cmd)  cmdPayload <= byteData[PAY_W-1:0];
      if (stb.data) dataByte   <= byteData;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdStrobe, dataStrobe})); // R10

  AST_STROBE_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe || dataStrobe) |-> ackOut); // R4

endmodule

// File: rtl/segStreamSorter.sv
module segStreamSorter
  import seg_sorter_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DEV_ADDR = 8'h7C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output logic              ackOut,
  output logic              cmdStrobe,
  output logic [PAY_W-1:0]  cmdPayload,
  output logic              dataStrobe,
  output logic [BYTE_W-1:0] dataByte
);

  strobes_t stb;

  seg_sorter_ctrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startEv   (startEv),
    .stopEv    (stopEv),
    .byteValid (byteValid),
    .byteData  (byteData),
    .stb       (stb)
  );

  seg_sorter_dpath uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .byteData   (byteData),
    .ackOut     (ackOut),
    .cmdStrobe  (cmdStrobe),
    .cmdPayload (cmdPayload),
    .dataStrobe (dataStrobe),
    .dataByte   (dataByte)
  );

endmodule

// File: tb/sim_segStreamSorter.sv
`timescale 1ns/1ps
module sim_segStreamSorter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startEv = 1'b0;
  logic       stopEv = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic       ackOut, cmdStrobe, dataStrobe;
  logic [6:0] cmdPayload;
  logic [7:0] dataByte;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam logic [7:0] ADDR = 8'h7C;

  always #4 clk = ~clk;

  segStreamSorter u0 (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .byteValid(byteValid), .byteData(byteData), .ackOut(ackOut),
    .cmdStrobe(cmdStrobe), .cmdPayload(cmdPayload),
    .dataStrobe(dataStrobe), .dataByte(dataByte)
  );

  task automatic chk(input string req, input bit eAck, input bit eCmd, input bit eData,
                     input logic [7:0] eVal);
    bit ok;
    ok = (ackOut == eAck) && (cmdStrobe == eCmd) && (dataStrobe == eData);
    if (ok && eCmd)  ok = (cmdPayload == eVal[6:0]);
    if (ok && eData) ok = (dataByte == eVal);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got ack=%0b cmd=%0b data=%0b pay=%h byte=%h exp ack=%0b cmd=%0b data=%0b val=%h",
               req, ackOut, cmdStrobe, dataStrobe, cmdPayload, dataByte, eAck, eCmd, eData, eVal);
    end
  endtask

  // drive for one cycle at negedge; outputs are sampled at the next negedge
  task automatic ev(input bit s, input bit p, input bit v, input logic [7:0] b);
    @(negedge clk);
    startEv = s; stopEv = p; byteValid = v; byteData = b;
    @(negedge clk);
    startEv = 0; stopEv = 0; byteValid = 0;
  endtask

  task automatic sendB(input logic [7:0] b); ev(0, 0, 1, b); endtask
  task automatic doStart(); ev(1, 0, 0, 8'h00); endtask
  task automatic doStop();  ev(0, 1, 0, 8'h00); endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset", 0, 0, 0, 0);
    sendB(ADDR); chk("R1 no start", 0, 0, 0, 0);
    sendB(8'h80); chk("R1 no start", 0, 0, 0, 0);

    // R2/R3: sweep all address values
    for (int a = 0; a < 256; a++) begin
      doStart();
      sendB(a[7:0]);
      chk("R2 addr", a[7:0] == ADDR, 0, 0, 0);
      if (a[7:0] != ADDR) begin
        sendB(8'h00); chk("R3 reject", 0, 0, 0, 0);
        sendB(8'h81); chk("R3 reject", 0, 0, 0, 0);
      end
      doStop();
    end

    // R4/R5/R6: sweep all command values and their follower
    for (int c = 0; c < 256; c++) begin
      logic [7:0] nb;
      nb = 8'(c * 37 + 11);
      doStart(); sendB(ADDR);
      sendB(c[7:0]); chk("R4 cmd", 1, 1, 0, c[7:0]);
      sendB(nb);
      if (c[7]) chk("R5 cont", 1, 1, 0, nb);
      else      chk("R6 data", 1, 0, 1, nb);
      if (!c[7]) begin
        sendB(8'hFF); chk("R6 sticky", 1, 0, 1, 8'hFF);
        sendB(8'h80); chk("R6 sticky", 1, 0, 1, 8'h80);
      end
    end

    // R7: coincident events
    doStart(); sendB(ADDR); sendB(8'h85);
    ev(0, 1, 1, 8'h01); chk("R7 stop+byte", 0, 0, 0, 0);
    sendB(8'h01); chk("R7 idle after stop", 0, 0, 0, 0);
    doStart(); sendB(ADDR);
    ev(1, 0, 1, 8'h02); chk("R7 start+byte", 0, 0, 0, 0);
    sendB(ADDR); chk("R7 addr after start", 1, 0, 0, 0);
    sendB(8'h03); chk("R7 cmd", 1, 1, 0, 8'h03);
    sendB(8'hA5); chk("R7 data", 1, 0, 1, 8'hA5);
    ev(1, 1, 1, 8'h44); chk("R7 both+byte", 0, 0, 0, 0);
    sendB(ADDR); chk("R7 start wins", 1, 0, 0, 0);
    sendB(8'h86); chk("R7 cmd", 1, 1, 0, 8'h86);
    ev(1, 0, 1, 8'h07); chk("R7 start in cmd", 0, 0, 0, 0);
    sendB(8'h07); chk("R7 addr phase", 0, 0, 0, 0);

    // R8: stop from data phase
    doStart(); sendB(ADDR); sendB(8'h00); sendB(8'h11);
    chk("R8 data", 1, 0, 1, 8'h11);
    doStop(); sendB(8'h22); chk("R8 idle", 0, 0, 0, 0);

    // R9: repeated start from data phase reopens commands
    doStart(); sendB(ADDR); sendB(8'h00); sendB(8'h33);
    doStart(); sendB(ADDR); chk("R9 readdr", 1, 0, 0, 0);
    sendB(8'h9A); chk("R9 cmd again", 1, 1, 0, 8'h9A);

    // R10: strobe lasts one cycle
    @(negedge clk); chk("R10 single pulse", 0, 0, 0, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule